// File: doc/BRIEF.md
# SPI Controller FIFO and Event Block

This block is the buffering and status half of a serial peripheral controller. Software sends data by writing 32-bit words into a transmit byte FIFO. Software collects data from a receive byte FIFO, reading either a whole word or a single byte at a time. The serial shift engine sits on the other side of both FIFOs and moves one byte per handshake. Its sends are taken from the transmit FIFO and its captures are pushed into the receive FIFO.

A small register set sits beside the FIFOs:
- A mode word holds two threshold fields.
- A command word is plain storage for the engine.
- An event word reports two sticky status flags next to the live byte count of each FIFO. Writing ones to it clears flags.
- A mask word picks which flags drive the single interrupt output.

Registers are selected by a 3-bit index:
- 0: mode
- 1: event
- 2: mask
- 3: command
- 4: transmit data
- 5: receive data

Read data is registered and appears on the cycle after the read strobe. Each FIFO depth must be a power of two and no more than 63 bytes.

Top module: `spib_buffer_ctrl`

## Requirements
- R1: After reset, the mode, mask and command registers read zero and the interrupt is low. A value written to the command register (index 3) reads back unchanged.
- R2: A write to index 4 pushes four bytes into the transmit FIFO, bits 31:24 first. The engine receives them in that order on `eng_tx_data`, which is valid whenever the FIFO holds a byte.
- R3: Transmit bytes that do not fit in the 32-byte FIFO are dropped. The transmit count never exceeds 32.
- R4: A word read of index 5 pops up to four bytes. The earliest received byte is placed in bits 31:24.
- R5: A byte read of index 5 (`reg_byte` high) pops one byte. That byte is returned in bits 7:0 and the upper bits are zero.
- R6: A read slot with no byte behind it returns zero and pops nothing. A word read with fewer than four bytes stored fills its low bytes with zero and empties the FIFO.
- R7: A byte pushed by the engine into a full receive FIFO is dropped. The receive count stays at 32.
- R8: The event register (index 1) reports the receive count in bits 29:24 and the transmit count in bits 21:16.
- R9: Event bit 9 (receive ready) becomes set when the receive count is strictly greater than the receive threshold. That threshold is mode bits 5:0.
- R10: Event bit 8 (transmit room) becomes set when the transmit free space is at or above the transmit threshold. That threshold is mode bits 13:8.
- R11: Event bits are sticky. Writing a one to a bit clears it. A flag whose condition has gone stays clear, and writing all ones clears both flags.
- R12: The interrupt is high when any event bit is set with its mask bit set. Mask bits are 9 and 8, the same positions as the event bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register index |
| reg_byte | input | 1 | Byte-wide access to the receive register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| eng_tx_valid | output | 1 | Transmit FIFO holds a byte |
| eng_tx_data | output | 8 | Oldest transmit byte |
| eng_tx_take | input | 1 | Engine consumes the transmit byte |
| eng_rx_put | input | 1 | Engine pushes a received byte |
| eng_rx_data | input | 8 | Received byte |
| irq | output | 1 | Masked event interrupt |

## Verification
The hardest state to reach is the receive FIFO at its limit. In that state overflow bytes must vanish, and afterwards a final word read must find fewer than four bytes and pad with zeros. Directed stimulus overfills the FIFO with 34 pushes and drains it by words. It then leaves two bytes stored and word-reads them. Sticky flags are driven by raising a count past a threshold, clearing the flag while the condition still holds, and then removing the condition. Random mixes of pushes, word and byte reads, word writes and engine takes are checked against byte-queue models.

// File: rtl/spib_pkg.sv
package spib_pkg;
  typedef enum logic [2:0] {
    REG_MODE  = 3'd0,
    REG_EVENT = 3'd1,
    REG_MASK  = 3'd2,
    REG_CMD   = 3'd3,
    REG_TXD   = 3'd4,
    REG_RXD   = 3'd5
  } reg_sel_e;

  localparam int unsigned THR_W      = 6;
  localparam int unsigned CNT_W      = 6;
  localparam int unsigned BIT_RNE    = 9;
  localparam int unsigned BIT_TNF    = 8;
  localparam int unsigned TXTHR_LSB  = 8;
  localparam int unsigned RXTHR_LSB  = 0;
  localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/spib_byte_fifo.sv
// Byte FIFO accepting up to PUSH_W bytes and releasing up to POP_W bytes
// per cycle. Multi-byte fields are ordered most significant byte first.
module spib_byte_fifo #(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned PUSH_W = 1,
  parameter int unsigned POP_W  = 1,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CW    = AW + 1,
  localparam int unsigned PSW   = $clog2(PUSH_W + 1),
  localparam int unsigned PPW   = $clog2(POP_W + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [PSW-1:0]      push_req,
  input  logic [8*PUSH_W-1:0] push_data,
  input  logic [PPW-1:0]      pop_req,
  output logic [8*POP_W-1:0]  pop_data,
  output logic [CW-1:0]       count
);
  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] free_sp, push_acc, pop_acc;

  assign free_sp  = CW'(DEPTH) - count;
  assign push_acc = (CW'(push_req) > free_sp) ? free_sp : CW'(push_req);
  assign pop_acc  = (CW'(pop_req) > count) ? count : CW'(pop_req);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      wr_ptr <= wr_ptr + push_acc[AW-1:0];
      rd_ptr <= rd_ptr + pop_acc[AW-1:0];
      count  <= count + push_acc - pop_acc;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < PUSH_W; i++) begin
      if (CW'(i) < push_acc)
        mem[wr_ptr + AW'(i)] <= push_data[8*(PUSH_W-1-i) +: 8];
    end
  end

  always_comb begin
    for (int i = 0; i < POP_W; i++) begin
      pop_data[8*(POP_W-1-i) +: 8] = (CW'(i) < count) ? mem[rd_ptr + AW'(i)] : 8'h00;
    end
  end
endmodule

// File: rtl/spib_event_unit.sv
// Sticky status flags derived from FIFO counts, write-one-to-clear, and
// the registered masked interrupt.
module spib_event_unit #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = 6,
  parameter int unsigned TW    = 6,
  localparam int unsigned XW   = ((CW > TW) ? CW : TW) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_count,
  input  logic [TW-1:0] rx_thr,
  input  logic [TW-1:0] tx_thr,
  input  logic          clr_rne,
  input  logic          clr_tnf,
  input  logic          msk_rne,
  input  logic          msk_tnf,
  output logic          ev_rne,
  output logic          ev_tnf,
  output logic          irq
);
  logic          cond_rne, cond_tnf;
  logic [XW-1:0] tx_room;

  assign tx_room  = XW'(DEPTH) - XW'(tx_count);
  assign cond_rne = XW'(rx_count) > XW'(rx_thr);
  assign cond_tnf = tx_room >= XW'(tx_thr);

  always_ff @(posedge clk) begin
    if (rst) begin
      ev_rne <= 1'b0;
      ev_tnf <= 1'b0;
      irq    <= 1'b0;
    end else begin
      ev_rne <= (ev_rne | cond_rne) & ~clr_rne;
      ev_tnf <= (ev_tnf | cond_tnf) & ~clr_tnf;
      irq    <= (ev_rne & msk_rne) | (ev_tnf & msk_tnf);
    end
  end
endmodule

// File: rtl/spib_buffer_ctrl.sv
module spib_buffer_ctrl #(
  parameter int unsigned DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_sel,
  input  logic        reg_byte,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        eng_tx_valid,
  output logic [7:0]  eng_tx_data,
  input  logic        eng_tx_take,
  input  logic        eng_rx_put,
  input  logic [7:0]  eng_rx_data,
  output logic        irq
);
  import spib_pkg::*;

  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic [THR_W-1:0] thr_tx, thr_rx;
  logic             mask_rne, mask_tnf;
  logic [31:0]      cmd_q;
  logic [CW-1:0]    tx_cnt, rx_cnt;
  logic             ev_rne, ev_tnf;
  logic [2:0]       tx_push_n, rx_pop_n;
  logic [31:0]      rx_word;
  logic             wr_mode, wr_ev, wr_mask, wr_cmd, wr_txd, rd_rxd;

  assign wr_mode = reg_wr && (reg_sel == REG_MODE);
  assign wr_ev   = reg_wr && (reg_sel == REG_EVENT);
  assign wr_mask = reg_wr && (reg_sel == REG_MASK);
  assign wr_cmd  = reg_wr && (reg_sel == REG_CMD);
  assign wr_txd  = reg_wr && (reg_sel == REG_TXD);
  assign rd_rxd  = reg_rd && (reg_sel == REG_RXD);

  assign tx_push_n = wr_txd ? 3'(WORD_BYTES) : 3'd0;
  assign rx_pop_n  = rd_rxd ? (reg_byte ? 3'd1 : 3'(WORD_BYTES)) : 3'd0;

  spib_byte_fifo #(.DEPTH(DEPTH), .PUSH_W(WORD_BYTES), .POP_W(1)) u_txq (
    .clk       (clk),
    .rst       (rst),
    .push_req  (tx_push_n),
    .push_data (reg_wdata),
    .pop_req   (eng_tx_take),
    .pop_data  (eng_tx_data),
    .count     (tx_cnt)
  );

  spib_byte_fifo #(.DEPTH(DEPTH), .PUSH_W(1), .POP_W(WORD_BYTES)) u_rxq (
    .clk       (clk),
    .rst       (rst),
    .push_req  (eng_rx_put),
    .push_data (eng_rx_data),
    .pop_req   (rx_pop_n),
    .pop_data  (rx_word),
    .count     (rx_cnt)
  );

  assign eng_tx_valid = (tx_cnt != '0);

  spib_event_unit #(.DEPTH(DEPTH), .CW(CW), .TW(THR_W)) u_evt (
    .clk      (clk),
    .rst      (rst),
    .rx_count (rx_cnt),
    .tx_count (tx_cnt),
    .rx_thr   (thr_rx),
    .tx_thr   (thr_tx),
    .clr_rne  (wr_ev && reg_wdata[BIT_RNE]),
    .clr_tnf  (wr_ev && reg_wdata[BIT_TNF]),
    .msk_rne  (mask_rne),
    .msk_tnf  (mask_tnf),
    .ev_rne   (ev_rne),
    .ev_tnf   (ev_tnf),
    .irq      (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      thr_tx   <= '0;
      thr_rx   <= '0;
      mask_rne <= 1'b0;
      mask_tnf <= 1'b0;
      cmd_q    <= '0;
    end else begin
      if (wr_mode) begin
        thr_tx <= reg_wdata[TXTHR_LSB +: THR_W];
        thr_rx <= reg_wdata[RXTHR_LSB +: THR_W];
      end
      if (wr_mask) begin
        mask_rne <= reg_wdata[BIT_RNE];
        mask_tnf <= reg_wdata[BIT_TNF];
      end
      if (wr_cmd) cmd_q <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_sel)
        REG_MODE:  reg_rdata <= {18'b0, thr_tx, 2'b0, thr_rx};
        REG_EVENT: reg_rdata <= {2'b0, CNT_W'(rx_cnt), 2'b0, CNT_W'(tx_cnt),
                                 6'b0, ev_rne, ev_tnf, 8'b0};
        REG_MASK:  reg_rdata <= {22'b0, mask_rne, mask_tnf, 8'b0};
        REG_CMD:   reg_rdata <= cmd_q;
        REG_RXD:   reg_rdata <= reg_byte ? {24'b0, rx_word[31:24]} : rx_word;
        default:   reg_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/spib_checker.sv
module spib_checker #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned CW    = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_sel,
  input logic [31:0]   reg_wdata,
  input logic          eng_rx_put,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic [5:0]    thr_rx,
  input logic          ev_rne,
  input logic          mask_rne,
  input logic          mask_tnf,
  input logic          irq
);
  logic clr9, rx_read;
  assign clr9    = reg_wr && (reg_sel == 3'd1) && reg_wdata[9];
  assign rx_read = reg_rd && (reg_sel == 3'd5);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    int'(tx_cnt) <= int'(DEPTH));

  p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (int'(rx_cnt) == int'(DEPTH) && !rx_read) |=> int'(rx_cnt) == int'(DEPTH));

  p_empty_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rx_cnt == '0 && !eng_rx_put) |=> rx_cnt == '0);

  p_ready_set_r9: assert property (@(posedge clk) disable iff (rst)
    (int'(rx_cnt) > int'(thr_rx) && !clr9) |=> ev_rne);

  p_clear_r11: assert property (@(posedge clk) disable iff (rst)
    clr9 |=> !ev_rne);

  p_irq_masked_r12: assert property (@(posedge clk) disable iff (rst)
    (!mask_rne && !mask_tnf) |=> !irq);
endmodule

bind spib_buffer_ctrl spib_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_wr     (reg_wr),
  .reg_rd     (reg_rd),
  .reg_sel    (reg_sel),
  .reg_wdata  (reg_wdata),
  .eng_rx_put (eng_rx_put),
  .tx_cnt     (tx_cnt),
  .rx_cnt     (rx_cnt),
  .thr_rx     (thr_rx),
  .ev_rne     (ev_rne),
  .mask_rne   (mask_rne),
  .mask_tnf   (mask_tnf),
  .irq        (irq)
);

// File: tb/tb_spib_buffer_ctrl.sv
module tb_spib_buffer_ctrl;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_byte = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        eng_tx_valid, eng_tx_take = 1'b0, eng_rx_put = 1'b0;
  logic [7:0]  eng_tx_data, eng_rx_data = '0;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  logic [7:0] q_tx[$];
  logic [7:0] q_rx[$];

  always #2 clk = ~clk;

  spib_buffer_ctrl #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_byte(reg_byte), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .eng_tx_valid(eng_tx_valid), .eng_tx_data(eng_tx_data), .eng_tx_take(eng_tx_take),
    .eng_rx_put(eng_rx_put), .eng_rx_data(eng_rx_data), .irq(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [2:0] sel, logic [31:0] d);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] sel, logic bytewise, output logic [31:0] d);
    reg_rd = 1'b1; reg_sel = sel; reg_byte = bytewise;
    @(negedge clk);
    reg_rd = 1'b0; reg_byte = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rx_put(logic [7:0] b);
    eng_rx_put = 1'b1; eng_rx_data = b;
    @(negedge clk);
    eng_rx_put = 1'b0;
    if (q_rx.size() < DEPTH) q_rx.push_back(b);
  endtask

  task automatic tx_write(logic [31:0] w);
    wr(3'd4, w);
    for (int i = 3; i >= 0; i--)
      if (q_tx.size() < DEPTH) q_tx.push_back(w[8*i +: 8]);
  endtask

  task automatic tx_take(string tag);
    check({tag, " R2 valid"}, {31'b0, eng_tx_valid}, {31'b0, q_tx.size() > 0});
    if (q_tx.size() > 0) check({tag, " R2 data"}, {24'b0, eng_tx_data}, {24'b0, q_tx[0]});
    eng_tx_take = 1'b1;
    @(negedge clk);
    eng_tx_take = 1'b0;
    if (q_tx.size() > 0) void'(q_tx.pop_front());
  endtask

  function automatic logic [31:0] model_rx(logic bytewise);
    logic [31:0] r = '0;
    int n = bytewise ? 1 : 4;
    for (int i = 0; i < n; i++) begin
      logic [7:0] b = 8'h00;
      if (q_rx.size() > 0) b = q_rx.pop_front();
      if (bytewise) r[7:0] = b; else r[8*(3-i) +: 8] = b;
    end
    return r;
  endfunction

  task automatic rx_read(string tag, logic bytewise);
    logic [31:0] d, e;
    rd(3'd5, bytewise, d);
    e = model_rx(bytewise);
    check(tag, d, e);
  endtask

  function automatic logic [31:0] cnt_field();
    return (32'(q_rx.size()) << 24) | (32'(q_tx.size()) << 16);
  endfunction

  task automatic ev_check(string tag, logic [1:0] flags);
    logic [31:0] d;
    idle(3);
    rd(3'd1, 1'b0, d);
    check(tag, d, cnt_field() | {22'b0, flags, 8'b0});
  endtask

  task automatic cnt_check(string tag);
    logic [31:0] d;
    rd(3'd1, 1'b0, d);
    check(tag, d & 32'h3F3F_0000, cnt_field());
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'h1357_2468));
    idle(3);
    rst = 1'b0;
    idle(2);

    // R1 reset state
    rd(3'd0, 1'b0, d); check("R1 mode", d, 32'h0);
    rd(3'd2, 1'b0, d); check("R1 mask", d, 32'h0);
    rd(3'd3, 1'b0, d); check("R1 cmd", d, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    ev_check("R1 R10 event after reset", 2'b01);
    wr(3'd3, 32'hCAFE_0042);
    rd(3'd3, 1'b0, d); check("R1 cmd readback", d, 32'hCAFE_0042);

    // R2 byte order, R8 counts
    tx_write(32'hA1B2_C3D4);
    cnt_check("R8 tx count 4");
    for (int i = 0; i < 4; i++) tx_take("R2 order");
    check("R2 empty", {31'b0, eng_tx_valid}, 32'h0);

    // R3 overfill transmit
    for (int i = 0; i < 9; i++) tx_write(32'h1020_3040 + 32'(i) * 32'h0101_0101);
    cnt_check("R3 tx count saturates");
    for (int i = 0; i < DEPTH; i++) tx_take("R3 drain");

    // R4 R5 R6 receive reads
    for (int i = 0; i < 5; i++) rx_put(8'h10 + 8'(i));
    rx_read("R4 word", 1'b0);
    rx_read("R5 byte", 1'b0 | 1'b1);
    rx_read("R6 empty word", 1'b0);
    rx_read("R6 empty byte", 1'b1);
    cnt_check("R6 count stays zero");
    rx_put(8'hE1); rx_put(8'hE2);
    rx_read("R6 partial word", 1'b0);
    cnt_check("R6 partial empties");

    // R7 overfill receive
    for (int i = 0; i < DEPTH + 2; i++) rx_put(8'(i * 7 + 1));
    cnt_check("R7 rx count saturates");
    for (int i = 0; i < DEPTH / 4; i++) rx_read("R7 drain", 1'b0);

    // R9 R11 receive-ready flag
    wr(3'd0, (32'd40 << 8) | 32'd3);
    wr(3'd1, 32'hFFFF_FFFF);
    ev_check("R11 clear all", 2'b00);
    for (int i = 0; i < 3; i++) rx_put(8'h50 + 8'(i));
    ev_check("R9 at threshold", 2'b00);
    rx_put(8'h53);
    ev_check("R9 above threshold", 2'b10);
    wr(3'd1, 32'h0000_0200);
    ev_check("R11 re-set while held", 2'b10);
    rx_read("R4 word at threshold", 1'b0);
    ev_check("R11 sticky", 2'b10);
    wr(3'd1, 32'h0000_0200);
    ev_check("R11 cleared", 2'b00);

    // R10 transmit-room flag
    wr(3'd0, (32'd30 << 8) | 32'd3);
    ev_check("R10 room", 2'b01);
    tx_write(32'h0102_0304);
    wr(3'd1, 32'h0000_0100);
    ev_check("R10 below threshold", 2'b00);
    tx_take("R10 take"); tx_take("R10 take");
    ev_check("R10 room again", 2'b01);

    // R12 interrupt masking
    wr(3'd2, 32'h0000_0100); idle(3);
    check("R12 irq on", {31'b0, irq}, 32'h1);
    wr(3'd2, 32'h0000_0200); idle(3);
    check("R12 irq masked", {31'b0, irq}, 32'h0);
    wr(3'd2, 32'h0); idle(3);
    check("R12 irq off", {31'b0, irq}, 32'h0);

    // random mix
    wr(3'd0, 32'h0);
    for (int k = 0; k < 500; k++) begin
      case ($urandom_range(0, 5))
        0, 1: rx_put(8'($urandom));
        2: rx_read("R4 R5 random read", 1'($urandom));
        3: tx_write($urandom);
        4: tx_take("R2 random");
        default: cnt_check("R8 random counts");
      endcase
    end

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule